// File: doc/BRIEF.md
# Framed Register Command Decoder

This block sits behind a byte-wide transport and turns a stream of framed commands into display-controller register state. Each frame opens with a sync byte and an opcode. The register-write opcode carries an address and a data byte. The copy opcode carries a source address, a pixel count and a destination address. The block does not act on a copy. It only extracts the fields and reports them on a side port for a downstream pixel engine.

Every register write lands in a shadow bank. A dedicated control address opens and closes an atomic group. While the group is open, the live registers stay frozen. Closing the group moves the whole shadow bank into the live bank in one clock. The live bank is presented in full. Two 24-bit framebuffer base pointers and the colour-depth selection are decoded from it. The input accepts one byte per cycle (`in_ready` is always high), and `in_last` marks the final byte of a transfer.

The parser has five states. HUNT waits for the sync byte. OPCODE reads the command code. WADDR takes the register address. WDATA takes the data byte and issues the write. COPY gathers the seven copy bytes.

The transitions are:
- HUNT→OPCODE on 0xAF without `in_last`.
- OPCODE→WADDR on 0x20.
- OPCODE→COPY on 0x6A.
- OPCODE→HUNT on any other code, or on `in_last`.
- WADDR→WDATA, or WADDR→HUNT on `in_last`.
- WDATA→HUNT always.
- COPY→HUNT after the seventh byte, or on `in_last`.

Top module: `regcmd_decoder`

## Requirements
- R1: A frame 0xAF, 0x20, A, D with A below NREG, accepted while unlocked, sets live register A to D. The change is visible from the second clock after the D handshake.
- R2: Writing 0x00 to address 0xFF locks the bank. While locked, writes reach only the shadow bank and the live bank stays unchanged.
- R3: Writing 0xFF to address 0xFF unlocks the bank and copies every shadow register into the live bank in the same clock. Any other value written to 0xFF has no effect.
- R4: `base16_o` is {reg 0x20, reg 0x21, reg 0x22} and `base8_o` is {reg 0x26, reg 0x27, reg 0x28}. The first register named in each group is the most significant byte.
- R5: `depth_o` shows live register 0x00. `depth16_o` is high exactly when that register is 0, which selects 16 bits per pixel.
- R6: A frame 0xAF, 0x6A followed by seven bytes yields a one-cycle `cp_valid_o` in the clock after the seventh byte. The seven bytes are the source address (3 bytes, MSB first), the count (1 byte) and the destination address (3 bytes, MSB first).
- R7: A non-0xAF byte received in HUNT raises `err_o` for one clock, in the clock after that byte, and the parser stays in HUNT.
- R8: An opcode other than 0x20 or 0x6A raises a one-clock `err_o` and returns the parser to HUNT.
- R9: A lone 0xAF carrying `in_last` is padding. It raises no error and changes nothing.
- R10: A command cut short by `in_last` raises a one-clock `err_o`, is discarded, and leaves the parser in HUNT.
- R11: After reset, the bank is unlocked, all live registers are zero, `err_o` and `cp_valid_o` are low, and the parser is in HUNT.
- R12: A write to an address of NREG or above, other than 0xFF, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Always high; one byte accepted per cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of a transfer |
| err_o | output | 1 | One-cycle framing error pulse |
| cp_valid_o | output | 1 | One-cycle copy-report strobe |
| cp_src_o | output | 24 | Copy source address |
| cp_count_o | output | 8 | Copy pixel count |
| cp_dst_o | output | 24 | Copy destination address |
| reg_live_o | output | NREG*8 | Live register file, register i at bits [8i+7:8i] |
| base16_o | output | 24 | 16bpp segment base pointer |
| base8_o | output | 24 | 8bpp segment base pointer |
| depth_o | output | 8 | Colour-depth register |
| depth16_o | output | 1 | High when depth selects 16bpp |

## Verification
An unlock write that commits the shadow bank can arrive on a byte that also carries `in_last`. This ends the transfer in the same clock as the group commit. Likewise, a bad sync byte flagged with `in_last` produces an error and a transfer end together. The bench builds both cases on purpose and also mixes them into a long pseudo-random command stream. A behavioural model built on queues and integers predicts the error pulse, the copy report and the full live bank for every clock, and all of these are compared at each falling edge.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
    localparam logic [7:0] SYNC_BYTE  = 8'hAF;
    localparam logic [7:0] OP_WRITE   = 8'h20;
    localparam logic [7:0] OP_COPY    = 8'h6A;
    localparam logic [7:0] CTRL_ADDR  = 8'hFF;
    localparam logic [7:0] CTRL_HOLD  = 8'h00;
    localparam logic [7:0] CTRL_APPLY = 8'hFF;

    localparam int DEPTH_REG  = 8'h00;
    localparam int B16_HI_REG = 8'h20;
    localparam int B8_HI_REG  = 8'h26;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPCODE,
        ST_WADDR,
        ST_WDATA,
        ST_COPY
    } pstate_t;
endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
    import regcmd_pkg::*;
#(
    parameter int AW_BYTES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    output logic                  wr_stb,
    output logic [7:0]            wr_addr,
    output logic [7:0]            wr_data,
    output logic                  cp_valid,
    output logic [AW_BYTES*8-1:0] cp_src,
    output logic [7:0]            cp_cnt,
    output logic [AW_BYTES*8-1:0] cp_dst,
    output logic                  err
);
    localparam int COPY_BYTES = 2 * AW_BYTES + 1;
    localparam int SHW        = COPY_BYTES * 8;
    localparam int AWB        = AW_BYTES * 8;
    localparam int CW         = $clog2(COPY_BYTES);

    pstate_t        state, nxt;
    logic [CW-1:0]  cnt;
    logic [SHW-1:0] sh;
    logic [7:0]     addr_q;
    logic           copy_done;

    assign copy_done = (cnt == CW'(COPY_BYTES - 1));

    always_comb begin
        nxt = state;
        if (in_valid) begin
            unique case (state)
                ST_HUNT:   nxt = (in_data == SYNC_BYTE && !in_last) ? ST_OPCODE : ST_HUNT;
                ST_OPCODE: begin
                    if (in_last)                 nxt = ST_HUNT;
                    else if (in_data == OP_WRITE) nxt = ST_WADDR;
                    else if (in_data == OP_COPY)  nxt = ST_COPY;
                    else                          nxt = ST_HUNT;
                end
                ST_WADDR:  nxt = in_last ? ST_HUNT : ST_WDATA;
                ST_WDATA:  nxt = ST_HUNT;
                ST_COPY:   nxt = (copy_done || in_last) ? ST_HUNT : ST_COPY;
                default:   nxt = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            cp_valid <= 1'b0;
            err      <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            addr_q   <= '0;
        end else begin
            wr_stb   <= 1'b0;
            cp_valid <= 1'b0;
            err      <= 1'b0;
            if (in_valid) begin
                unique case (state)
                    ST_HUNT:   err <= (in_data != SYNC_BYTE);
                    ST_OPCODE: begin
                        cnt <= '0;
                        err <= in_last || ((in_data != OP_WRITE) && (in_data != OP_COPY));
                    end
                    ST_WADDR: begin
                        addr_q <= in_data;
                        err    <= in_last;
                    end
                    ST_WDATA: begin
                        wr_stb  <= 1'b1;
                        wr_addr <= addr_q;
                        wr_data <= in_data;
                    end
                    ST_COPY: begin
                        sh  <= {sh[SHW-9:0], in_data};
                        cnt <= cnt + 1'b1;
                        if (copy_done)    cp_valid <= 1'b1;
                        else if (in_last) err      <= 1'b1;
                    end
                    default: err <= 1'b1;
                endcase
            end
        end
    end

    assign cp_src = sh[SHW-1 -: AWB];
    assign cp_cnt = sh[AWB +: 8];
    assign cp_dst = sh[AWB-1:0];
endmodule

// File: rtl/regcmd_bank.sv
module regcmd_bank
    import regcmd_pkg::*;
#(
    parameter int NREG = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] live_o,
    output logic [NREG*8-1:0] shadow_o,
    output logic              locked_o
);
    logic ctrl_hit, commit;

    assign ctrl_hit = wr_stb && (wr_addr == CTRL_ADDR);
    assign commit   = ctrl_hit && (wr_data == CTRL_APPLY);

    always_ff @(posedge clk) begin
        if (!rst_n)                                     locked_o <= 1'b0;
        else if (ctrl_hit && wr_data == CTRL_HOLD)      locked_o <= 1'b1;
        else if (commit)                                locked_o <= 1'b0;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit;
        assign hit = wr_stb && (wr_addr == 8'(i));

        always_ff @(posedge clk) begin
            if (!rst_n)   shadow_o[i*8 +: 8] <= '0;
            else if (hit) shadow_o[i*8 +: 8] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                  live_o[i*8 +: 8] <= '0;
            else if (commit)             live_o[i*8 +: 8] <= shadow_o[i*8 +: 8];
            else if (hit && !locked_o)   live_o[i*8 +: 8] <= wr_data;
        end
    end
endmodule

// File: rtl/regcmd_fields.sv
module regcmd_fields (
    input  logic [7:0]  r_depth,
    input  logic [7:0]  r16_hi,
    input  logic [7:0]  r16_mid,
    input  logic [7:0]  r16_lo,
    input  logic [7:0]  r8_hi,
    input  logic [7:0]  r8_mid,
    input  logic [7:0]  r8_lo,
    output logic [23:0] base16,
    output logic [23:0] base8,
    output logic [7:0]  depth,
    output logic        depth16
);
    assign base16  = {r16_hi, r16_mid, r16_lo};
    assign base8   = {r8_hi, r8_mid, r8_lo};
    assign depth   = r_depth;
    assign depth16 = (r_depth == 8'h00);
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
    import regcmd_pkg::*;
#(
    parameter int NREG     = 48,
    parameter int AW_BYTES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    output logic                  err_o,
    output logic                  cp_valid_o,
    output logic [AW_BYTES*8-1:0] cp_src_o,
    output logic [7:0]            cp_count_o,
    output logic [AW_BYTES*8-1:0] cp_dst_o,
    output logic [NREG*8-1:0]     reg_live_o,
    output logic [23:0]           base16_o,
    output logic [23:0]           base8_o,
    output logic [7:0]            depth_o,
    output logic                  depth16_o
);
    logic              wr_stb_w;
    logic [7:0]        wr_addr_w, wr_data_w;
    logic [NREG*8-1:0] shadow_w;
    logic              locked_w;

    assign in_ready = 1'b1;

    regcmd_parser #(.AW_BYTES(AW_BYTES)) u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .wr_stb(wr_stb_w), .wr_addr(wr_addr_w),
        .wr_data(wr_data_w), .cp_valid(cp_valid_o), .cp_src(cp_src_o),
        .cp_cnt(cp_count_o), .cp_dst(cp_dst_o), .err(err_o)
    );

    regcmd_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_w), .wr_addr(wr_addr_w),
        .wr_data(wr_data_w), .live_o(reg_live_o), .shadow_o(shadow_w),
        .locked_o(locked_w)
    );

    regcmd_fields u_fields (
        .r_depth(reg_live_o[DEPTH_REG*8 +: 8]),
        .r16_hi (reg_live_o[B16_HI_REG*8 +: 8]),
        .r16_mid(reg_live_o[(B16_HI_REG+1)*8 +: 8]),
        .r16_lo (reg_live_o[(B16_HI_REG+2)*8 +: 8]),
        .r8_hi  (reg_live_o[B8_HI_REG*8 +: 8]),
        .r8_mid (reg_live_o[(B8_HI_REG+1)*8 +: 8]),
        .r8_lo  (reg_live_o[(B8_HI_REG+2)*8 +: 8]),
        .base16(base16_o), .base8(base8_o), .depth(depth_o), .depth16(depth16_o)
    );
endmodule

// File: rtl/regcmd_decoder_chk.sv
module regcmd_decoder_chk #(
    parameter int NREG = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              err,
    input logic              cp_valid,
    input logic              wr_stb,
    input logic [7:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              locked,
    input logic [NREG*8-1:0] shadow,
    input logic [NREG*8-1:0] live
);
    logic [7:0] a_q, d_q;
    always_ff @(posedge clk) begin
        a_q <= wr_addr;
        d_q <= wr_data;
    end

    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && wr_stb && wr_addr < NREG) |=> (live[int'(a_q)*8 +: 8] == d_q));

    p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == 8'hFF && wr_data == 8'h00) |=> locked);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_stb && wr_addr != 8'hFF) |=> $stable(live));

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == 8'hFF && wr_data == 8'hFF) |=> (live == $past(shadow)));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && cp_valid));

    p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(in_valid));

    p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr >= NREG && wr_addr != 8'hFF) |=> ($stable(live) && $stable(shadow)));
endmodule

bind regcmd_decoder regcmd_decoder_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .err(err_o),
    .cp_valid(cp_valid_o), .wr_stb(wr_stb_w), .wr_addr(wr_addr_w),
    .wr_data(wr_data_w), .locked(locked_w), .shadow(shadow_w), .live(reg_live_o)
);

// File: tb/regcmd_decoder_bench.sv
module regcmd_decoder_bench;
    localparam int NREG = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, err_o, cp_valid_o, depth16_o;
    logic [23:0] cp_src_o, cp_dst_o, base16_o, base8_o;
    logic [7:0] cp_count_o, depth_o;
    logic [NREG*8-1:0] reg_live_o;

    always #5 clk = ~clk;

    regcmd_decoder #(.NREG(NREG)) u_regcmd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .err_o(err_o),
        .cp_valid_o(cp_valid_o), .cp_src_o(cp_src_o), .cp_count_o(cp_count_o),
        .cp_dst_o(cp_dst_o), .reg_live_o(reg_live_o), .base16_o(base16_o),
        .base8_o(base8_o), .depth_o(depth_o), .depth16_o(depth16_o)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model
    int mstate = 0;            // 0 hunt,1 opcode,2 addr,3 data,4 copy
    logic [7:0] m_shadow [NREG];
    logic [7:0] m_live   [NREG];
    bit m_locked = 0;
    bit pend_w = 0;
    int pend_a = 0, pend_d = 0, m_addr = 0;
    logic [7:0] m_q[$];
    bit exp_err = 0, exp_cv = 0;
    logic [23:0] exp_src = 0, exp_dst = 0;
    logic [7:0] exp_cnt = 0;

    function automatic logic [NREG*8-1:0] live_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_live[i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mstate = 0; m_locked = 0; pend_w = 0; exp_err = 0; exp_cv = 0;
            m_q.delete();
            for (int i = 0; i < NREG; i++) begin m_shadow[i] = 0; m_live[i] = 0; end
        end else begin
            exp_err = 0; exp_cv = 0;
            if (pend_w) begin
                if (pend_a == 255) begin
                    if (pend_d == 0) m_locked = 1;
                    else if (pend_d == 255) begin
                        m_locked = 0;
                        for (int i = 0; i < NREG; i++) m_live[i] = m_shadow[i];
                    end
                end else if (pend_a < NREG) begin
                    m_shadow[pend_a] = 8'(pend_d);
                    if (!m_locked) m_live[pend_a] = 8'(pend_d);
                end
                pend_w = 0;
            end
            if (in_valid) begin
                case (mstate)
                    0: begin
                        if (in_data != 8'hAF) exp_err = 1;
                        else if (!in_last) mstate = 1;
                    end
                    1: begin
                        if (in_last || (in_data != 8'h20 && in_data != 8'h6A)) begin
                            exp_err = 1; mstate = 0;
                        end else if (in_data == 8'h20) mstate = 2;
                        else begin mstate = 4; m_q.delete(); end
                    end
                    2: begin
                        m_addr = in_data;
                        if (in_last) begin exp_err = 1; mstate = 0; end
                        else mstate = 3;
                    end
                    3: begin
                        pend_w = 1; pend_a = m_addr; pend_d = in_data; mstate = 0;
                    end
                    default: begin
                        m_q.push_back(in_data);
                        if (m_q.size() == 7) begin
                            exp_cv = 1;
                            exp_src = {m_q[0], m_q[1], m_q[2]};
                            exp_cnt = m_q[3];
                            exp_dst = {m_q[4], m_q[5], m_q[6]};
                            mstate = 0;
                        end else if (in_last) begin
                            exp_err = 1; mstate = 0;
                        end
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [383:0] act, input logic [383:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(err_o == exp_err, "err_o R7 R8 R9 R10", 384'(err_o), 384'(exp_err));
            chk(cp_valid_o == exp_cv, "cp_valid R6", 384'(cp_valid_o), 384'(exp_cv));
            if (exp_cv)
                chk({cp_src_o, cp_count_o, cp_dst_o} == {exp_src, exp_cnt, exp_dst}, "copy fields R6",
                    384'({cp_src_o, cp_count_o, cp_dst_o}), 384'({exp_src, exp_cnt, exp_dst}));
            chk(reg_live_o == live_vec(), "live bank R1 R2 R3 R12", 384'(reg_live_o), 384'(live_vec()));
            chk(base16_o == {m_live[32], m_live[33], m_live[34]} && base8_o == {m_live[38], m_live[39], m_live[40]},
                "base pointers R4", 384'({base16_o, base8_o}),
                384'({m_live[32], m_live[33], m_live[34], m_live[38], m_live[39], m_live[40]}));
            chk(depth_o == m_live[0] && depth16_o == (m_live[0] == 0), "depth R5",
                384'({depth_o, depth16_o}), 384'({m_live[0], m_live[0] == 0}));
        end
    end

    // stimulus, all tasks entered at a falling edge
    task automatic put(input logic [7:0] b, input bit last = 0);
        in_valid = 1; in_data = b; in_last = last;
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit last = 0);
        put(8'hAF); put(8'h20); put(a); put(d, last);
    endtask

    task automatic cpy(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d, input bit last = 0);
        put(8'hAF); put(8'h6A);
        put(s[23:16]); put(s[15:8]); put(s[7:0]); put(n);
        put(d[23:16]); put(d[15:8]); put(d[7:0], last);
    endtask

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(reg_live_o == '0 && !err_o && !cp_valid_o && depth16_o && in_ready, "reset R11",
            384'({reg_live_o == '0, err_o, cp_valid_o, depth16_o}), 384'(4'b1001));
        wr(8'h05, 8'h3C); idle(2);                              // R1
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);   // R4
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF); idle(2);
        wr(8'h00, 8'h01); idle(2); wr(8'h00, 8'h00); idle(2);   // R5
        wr(8'hFF, 8'h00);                                       // R2 lock
        wr(8'h21, 8'hAA); wr(8'h01, 8'h77); wr(8'h00, 8'h02); idle(3);
        wr(8'hFF, 8'h55); idle(2);                              // R3 no effect
        wr(8'hFF, 8'hFF, 1); idle(3);                           // R3 commit with transfer end
        cpy(24'h010203, 8'h40, 24'hA0B0C0); idle(2);            // R6
        cpy(24'hFFFFFF, 8'h01, 24'h000000, 1); idle(2);
        put(8'h13); put(8'h13, 1); wr(8'h07, 8'h99); idle(2);   // R7
        put(8'hAF); put(8'h33); put(8'hAF); put(8'hAF); idle(2); // R8
        put(8'hAF, 1); idle(3);                                 // R9
        put(8'hAF); put(8'h20); put(8'h05, 1); idle(2);         // R10
        put(8'hAF); put(8'h6A); put(8'h01); put(8'h02, 1); idle(2);
        put(8'hAF); put(8'h20, 1); idle(2);
        wr(8'h40, 8'h5A); wr(8'h30, 8'h5B); idle(3);            // R12
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0: wr(8'hFF, 8'h00);
                3'd1: wr(8'hFF, 8'hFF, lf[3]);
                3'd2: cpy({lf, lf[7:0]}, lf[15:8], {lf[7:0], lf}, lf[4]);
                3'd3: put(lf[15:8], lf[5]);
                default: wr(8'(lf[8:3] % 6'd48), lf[15:8], lf[6]);
            endcase
            if (lf[9]) idle(1);
        end
        idle(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule